// File: doc/BRIEF.md
# Scripted DMA Instruction Sequencer

This block is a small DMA engine driven by a script held in system memory. It reads instructions through a 32-bit bus master port, starting at a script pointer. Each instruction opens with two bus words. The first word carries an 8-bit command byte and a 24-bit byte count. The second word carries a source or operand value. Instruction words arrive big-endian, so the block reverses their bytes before it decodes them.

The block runs two instruction classes. The first is a memory-to-memory block copy. It reads a third word that gives the destination, copies whole 32-bit words, then copies any leftover bytes one at a time, and moves on to the next instruction. The second is an interrupt instruction. It halts the sequencer and raises an interrupt without moving the script pointer.

Any other command counts as illegal. It halts the block and raises its own status bit. Once started, the block runs instructions back to back until something halts it.

Top module: `dma_script_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `halted`, `irq`, `int_pending`, `script_int` and `illegal_int` are 0, and `script_ptr` is 0.
- R2: A `start` pulse while idle loads `script_ptr` from `start_ptr`, clears `halted`, `int_pending`, `script_int` and `illegal_int`, and begins fetching.
- R3: Each instruction first reads the words at `script_ptr` and `script_ptr+4` and byte-reverses them (bus bits 7:0 become bits 31:24). Bits 31:24 of the first word load `cmd`. Bits 23:0 load `byte_count`. The second word loads `src_addr`.
- R4: A command is a memory move when (cmd AND 0xE0) equals 0xC0, and an interrupt when (cmd AND 0xF8) equals 0x98. Every other command is illegal.
- R5: A memory move reads a third word at `script_ptr+8`, byte-reversed, into `dst_addr`.
- R6: A memory move copies count/4 (rounded down) whole words, then count AND 3 single bytes, in ascending address order. Afterwards the destination range matches the source, and bytes past the end of the destination are untouched.
- R7: When a memory move finishes, `byte_count` is 0, `dst_addr` equals the start destination plus the count, and `script_ptr` has grown by 12. Execution then continues with the next instruction.
- R8: An interrupt instruction sets `halted`, `int_pending`, `script_int` and `irq`, stops bus activity, and leaves `script_ptr` pointing at itself.
- R9: An illegal instruction sets `halted`, `int_pending`, `illegal_int` and `irq`, leaves `script_int` at 0, and leaves `script_ptr` pointing at itself.
- R10: The block holds each bus request, with its address, direction and size, stable until `bus_ready` is seen. Wait states do not change any result.
- R11: Word accesses drive `bus_size`=0. Byte accesses drive `bus_size`=1 and carry the data on bits 7:0. A move of n bytes makes 2·(n AND 3) byte accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin running the script at `start_ptr` (acted on when idle) |
| start_ptr | input | ADDR_W | First instruction address |
| bus_req | output | 1 | Bus request valid |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_size | output | 1 | 0 = 32-bit word, 1 = single byte on bits 7:0 |
| bus_addr | output | ADDR_W | Byte address of the access |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with `bus_ready` |
| bus_ready | input | 1 | Completes the current request |
| busy | output | 1 | Sequencer is not idle |
| halted | output | 1 | Stopped by an interrupt or illegal instruction |
| irq | output | 1 | Interrupt request |
| int_pending | output | 1 | DMA interrupt pending status |
| script_int | output | 1 | Interrupt instruction seen |
| illegal_int | output | 1 | Illegal instruction seen |
| cmd | output | 8 | Last fetched command byte |
| script_ptr | output | ADDR_W | Script pointer |
| byte_count | output | 24 | Byte count register |
| src_addr | output | ADDR_W | Source / operand register |
| dst_addr | output | ADDR_W | Destination register |

## Verification
The assertions take for granted that `bus_ready` is only seen while `bus_req` is high. They also assume `start` arrives only while the block is idle, and that every script ends in an interrupt or illegal instruction so that the block halts. The bench memory model raises ready only on a live request, in some runs after wait states. The bench pulses `start` only after it has seen `busy` low, and it ends every script with a halting instruction.

// File: rtl/dss_pkg.sv
package dss_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_FETCH1,
      ST_FETCH2,
      ST_FETCH3,
      ST_WORD_RD,
      ST_WORD_WR,
      ST_BYTE_RD,
      ST_BYTE_WR,
      ST_DONE
   } dss_state_e;

   localparam int          DSS_DATA_W   = 32;
   localparam int          DSS_CMD_W    = 8;
   localparam logic [7:0]  DSS_MOVE_MSK = 8'hE0;
   localparam logic [7:0]  DSS_MOVE_VAL = 8'hC0;
   localparam logic [7:0]  DSS_INT_MSK  = 8'hF8;
   localparam logic [7:0]  DSS_INT_VAL  = 8'h98;

endpackage

// File: rtl/dss_swap.sv
module dss_swap #(
   parameter int  WIDTH = 32,
   parameter bit  SWAP  = 1'b1
) (
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   localparam int NBYTES = WIDTH / 8;

   initial assert (WIDTH % 8 == 0) else $error("dss_swap: WIDTH must be whole bytes");

   generate
      if (SWAP) begin : g_rev
         for (genvar b = 0; b < NBYTES; b++) begin : g_lane
            assign dout[b*8 +: 8] = din[(NBYTES-1-b)*8 +: 8];
         end
      end else begin : g_pass
         assign dout = din;
      end
   endgenerate
endmodule

// File: rtl/dss_decode.sv
module dss_decode
   import dss_pkg::*;
(
   input  logic [DSS_CMD_W-1:0] cmd,
   output logic                 is_move,
   output logic                 is_int,
   output logic                 is_bad
);
   always_comb begin
      is_move = (cmd & DSS_MOVE_MSK) == DSS_MOVE_VAL;
      is_int  = (cmd & DSS_INT_MSK)  == DSS_INT_VAL;
      is_bad  = !is_move && !is_int;
   end
endmodule

// File: rtl/dma_script_seq.sv
module dma_script_seq
   import dss_pkg::*;
#(
   parameter int  ADDR_W     = 32,
   parameter bit  FETCH_SWAP = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [ADDR_W-1:0]     start_ptr,
   output logic                  bus_req,
   output logic                  bus_we,
   output logic                  bus_size,
   output logic [ADDR_W-1:0]     bus_addr,
   output logic [31:0]           bus_wdata,
   input  logic [31:0]           bus_rdata,
   input  logic                  bus_ready,
   output logic                  busy,
   output logic                  halted,
   output logic                  irq,
   output logic                  int_pending,
   output logic                  script_int,
   output logic                  illegal_int,
   output logic [7:0]            cmd,
   output logic [ADDR_W-1:0]     script_ptr,
   output logic [23:0]           byte_count,
   output logic [ADDR_W-1:0]     src_addr,
   output logic [ADDR_W-1:0]     dst_addr
);
   localparam int CNT_W      = DSS_DATA_W - DSS_CMD_W;
   localparam int WORD_BYTES = DSS_DATA_W / 8;
   localparam int INSTR_LEN  = 3 * WORD_BYTES;

   initial assert (ADDR_W >= 8 && ADDR_W <= DSS_DATA_W)
      else $error("dma_script_seq: ADDR_W out of range");
   initial assert (CNT_W == 24) else $error("dma_script_seq: count field must be 24 bits");

   dss_state_e            state;
   logic [DSS_DATA_W-1:0] fetched;
   logic [DSS_DATA_W-1:0] data_q;
   logic                  xfer;
   logic                  d_move, d_int, d_bad;

   dss_swap #(.WIDTH(DSS_DATA_W), .SWAP(FETCH_SWAP)) u_swap (
      .din  (bus_rdata),
      .dout (fetched)
   );

   dss_decode u_dec (
      .cmd     (cmd),
      .is_move (d_move),
      .is_int  (d_int),
      .is_bad  (d_bad)
   );

   assign xfer = bus_req && bus_ready;
   assign busy = (state != ST_IDLE);
   assign irq  = int_pending;

   function automatic dss_state_e copy_next(input logic [CNT_W-1:0] n);
      if (|n[CNT_W-1:2])   return ST_WORD_RD;
      else if (|n[1:0])    return ST_BYTE_RD;
      else                 return ST_DONE;
   endfunction

   // bus request generation
   always_comb begin
      bus_req   = 1'b0;
      bus_we    = 1'b0;
      bus_size  = 1'b0;
      bus_addr  = script_ptr;
      bus_wdata = '0;
      unique case (state)
         ST_FETCH1:  bus_req = 1'b1;
         ST_FETCH2:  begin bus_req = 1'b1; bus_addr = script_ptr + ADDR_W'(WORD_BYTES);   end
         ST_FETCH3:  begin bus_req = 1'b1; bus_addr = script_ptr + ADDR_W'(2*WORD_BYTES); end
         ST_WORD_RD: begin bus_req = 1'b1; bus_addr = src_addr; end
         ST_WORD_WR: begin bus_req = 1'b1; bus_we = 1'b1; bus_addr = dst_addr; bus_wdata = data_q; end
         ST_BYTE_RD: begin bus_req = 1'b1; bus_size = 1'b1; bus_addr = src_addr; end
         ST_BYTE_WR: begin
            bus_req = 1'b1; bus_we = 1'b1; bus_size = 1'b1; bus_addr = dst_addr;
            bus_wdata = {24'h0, data_q[7:0]};
         end
         default: ;
      endcase
   end

   // sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         script_ptr  <= '0;
         src_addr    <= '0;
         dst_addr    <= '0;
         byte_count  <= '0;
         cmd         <= '0;
         data_q      <= '0;
         halted      <= 1'b0;
         int_pending <= 1'b0;
         script_int  <= 1'b0;
         illegal_int <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: if (start) begin
               script_ptr  <= start_ptr;
               halted      <= 1'b0;
               int_pending <= 1'b0;
               script_int  <= 1'b0;
               illegal_int <= 1'b0;
               state       <= ST_FETCH1;
            end
            ST_FETCH1: if (xfer) begin
               cmd        <= fetched[DSS_DATA_W-1 -: DSS_CMD_W];
               byte_count <= fetched[CNT_W-1:0];
               state      <= ST_FETCH2;
            end
            ST_FETCH2: if (xfer) begin
               src_addr <= fetched[ADDR_W-1:0];
               if (d_move) begin
                  state <= ST_FETCH3;
               end else begin
                  halted      <= 1'b1;
                  int_pending <= 1'b1;
                  script_int  <= d_int;
                  illegal_int <= d_bad;
                  state       <= ST_IDLE;
               end
            end
            ST_FETCH3: if (xfer) begin
               dst_addr <= fetched[ADDR_W-1:0];
               state    <= copy_next(byte_count);
            end
            ST_WORD_RD: if (xfer) begin
               data_q <= bus_rdata;
               state  <= ST_WORD_WR;
            end
            ST_WORD_WR: if (xfer) begin
               src_addr   <= src_addr + ADDR_W'(WORD_BYTES);
               dst_addr   <= dst_addr + ADDR_W'(WORD_BYTES);
               byte_count <= byte_count - CNT_W'(WORD_BYTES);
               state      <= copy_next(byte_count - CNT_W'(WORD_BYTES));
            end
            ST_BYTE_RD: if (xfer) begin
               data_q <= bus_rdata;
               state  <= ST_BYTE_WR;
            end
            ST_BYTE_WR: if (xfer) begin
               src_addr   <= src_addr + ADDR_W'(1);
               dst_addr   <= dst_addr + ADDR_W'(1);
               byte_count <= byte_count - CNT_W'(1);
               state      <= copy_next(byte_count - CNT_W'(1));
            end
            ST_DONE: begin
               script_ptr <= script_ptr + ADDR_W'(INSTR_LEN);
               state      <= ST_FETCH1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R10: pending request is held unchanged until accepted
   a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_size)));

   // R8 / R9: pointer moves only on a start or at the end of a move
   a_r8_ptr_moves: assert property (@(posedge clk) disable iff (!rst_n)
      (script_ptr != $past(script_ptr)) |-> ($past(state) == ST_DONE || $past(state) == ST_IDLE));

   // R8: once halted the bus stays quiet
   a_r8_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !bus_req);

   // R8: script interrupt always arrives with halt and pending
   a_r8_int_flags: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(script_int) |-> (halted && int_pending && !illegal_int));

   // R6: a word phase only runs with at least one whole word left
   a_r6_word_left: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WORD_RD) |-> (byte_count >= 24'd4));

   // R7: count is exhausted when a move retires
   a_r7_count_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DONE) |-> (byte_count == '0));
endmodule

// File: tb/dma_script_seq_bench.sv
module dma_script_seq_bench;
   typedef struct packed {
      logic [31:0] src;
      logic [31:0] dst;
      logic [23:0] cnt;
      logic        stall;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      vec_t'{32'h100, 32'h200, 24'd0,  1'b0},
      vec_t'{32'h104, 32'h208, 24'd1,  1'b0},
      vec_t'{32'h101, 32'h213, 24'd3,  1'b1},
      vec_t'{32'h100, 32'h220, 24'd4,  1'b0},
      vec_t'{32'h110, 32'h230, 24'd7,  1'b1},
      vec_t'{32'h120, 32'h240, 24'd8,  1'b0},
      vec_t'{32'h103, 32'h251, 24'd13, 1'b1},
      vec_t'{32'h130, 32'h260, 24'd32, 1'b1}
   };
   localparam logic [31:0] P = 32'h40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] start_ptr = '0;
   logic        bus_req, bus_we, bus_size, bus_ready;
   logic [31:0] bus_addr, bus_wdata, bus_rdata;
   logic        busy, halted, irq, int_pending, script_int, illegal_int;
   logic [7:0]  cmd;
   logic [31:0] script_ptr, src_addr, dst_addr;
   logic [23:0] byte_count;

   logic [7:0]  mem [0:1023];
   logic        stall_en = 1'b0;
   logic [1:0]  cyc = '0;
   int          n_word = 0, n_byte = 0;
   int          checks = 0, fails = 0;

   always #5 clk = ~clk;

   dma_script_seq u_dma_script_seq (
      .clk, .rst_n, .start, .start_ptr,
      .bus_req, .bus_we, .bus_size, .bus_addr, .bus_wdata, .bus_rdata, .bus_ready,
      .busy, .halted, .irq, .int_pending, .script_int, .illegal_int,
      .cmd, .script_ptr, .byte_count, .src_addr, .dst_addr
   );

   assign bus_ready = bus_req && (!stall_en || cyc == 2'b11);

   always_comb begin
      if (bus_size) bus_rdata = {24'h0, mem[bus_addr[9:0]]};
      else bus_rdata = {mem[10'(bus_addr[9:0] + 3)], mem[10'(bus_addr[9:0] + 2)],
                        mem[10'(bus_addr[9:0] + 1)], mem[bus_addr[9:0]]};
   end

   always @(posedge clk) begin
      cyc <= cyc + 2'd1;
      if (bus_req && bus_ready) begin
         if (bus_size) n_byte <= n_byte + 1; else n_word <= n_word + 1;
         if (bus_we) begin
            if (bus_size) mem[bus_addr[9:0]] <= bus_wdata[7:0];
            else begin
               mem[bus_addr[9:0]]            <= bus_wdata[7:0];
               mem[10'(bus_addr[9:0] + 1)]   <= bus_wdata[15:8];
               mem[10'(bus_addr[9:0] + 2)]   <= bus_wdata[23:16];
               mem[10'(bus_addr[9:0] + 3)]   <= bus_wdata[31:24];
            end
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic put_be(input logic [31:0] a, input logic [31:0] w);
      mem[a[9:0]]          = w[31:24];
      mem[10'(a[9:0] + 1)] = w[23:16];
      mem[10'(a[9:0] + 2)] = w[15:8];
      mem[10'(a[9:0] + 3)] = w[7:0];
   endtask

   task automatic run(input logic [31:0] ptr);
      int t = 0;
      @(negedge clk);
      start_ptr = ptr;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (busy && t < 5000) begin
         @(negedge clk);
         t++;
      end
      if (busy) begin
         checks++; fails++;
         $display("FAIL watchdog actual=busy expected=idle");
      end
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 busy", {31'b0, busy}, 32'h0);
      chk("R1 halted", {31'b0, halted}, 32'h0);
      chk("R1 irq", {29'b0, irq, int_pending, script_int}, 32'h0);
      chk("R1 ptr", script_ptr, 32'h0);
      rst_n = 1'b1;

      // vector table: one move then an interrupt instruction
      for (int v = 0; v < NV; v++) begin
         int w0, b0;
         vec_t e = VECS[v];
         stall_en = e.stall;
         for (int k = 0; k < 40; k++) begin
            mem[10'(e.src + 32'(k))] = 8'(k * 7 + v + 1);
            mem[10'(e.dst + 32'(k))] = 8'hEE;
         end
         put_be(P,       {8'hC0, e.cnt});
         put_be(P + 4,   e.src);
         put_be(P + 8,   e.dst);
         put_be(P + 12,  32'h98000055);
         put_be(P + 16,  32'hCAFEF00D);
         w0 = n_word; b0 = n_byte;
         run(P);
         chk("R7 ptr", script_ptr, P + 12);
         chk("R7 dst", dst_addr, e.dst + 32'(e.cnt));
         chk("R3 count load", {8'h0, byte_count}, 32'h55);
         chk("R3 src load", src_addr, 32'hCAFEF00D);
         chk("R3 cmd", {24'h0, cmd}, 32'h98);
         chk("R8 flags", {28'h0, halted, irq, int_pending, script_int}, 32'hF);
         chk("R9 no illegal", {31'h0, illegal_int}, 32'h0);
         chk("R11 byte xfers", 32'(n_byte - b0), 32'(2 * (e.cnt % 4)));
         chk("R10 word xfers", 32'(n_word - w0), 32'(5 + 2 * (e.cnt / 4)));
         for (int k = 0; k < int'(e.cnt); k++)
            chk("R6 copy", {24'h0, mem[10'(e.dst + 32'(k))]}, {24'h0, 8'(k * 7 + v + 1)});
         for (int k = int'(e.cnt); k < int'(e.cnt) + 4; k++)
            chk("R6 untouched", {24'h0, mem[10'(e.dst + 32'(k))]}, 32'hEE);
      end
      stall_en = 1'b0;

      // R7 / R5: two chained moves, second uses masked move code 0xDF
      put_be(P,      32'hC0000002); put_be(P + 4,  32'h140); put_be(P + 8,  32'h300);
      put_be(P + 12, 32'hDF000003); put_be(P + 16, 32'h150); put_be(P + 20, 32'h310);
      put_be(P + 24, 32'h98000000); put_be(P + 28, 32'h0);
      run(P);
      chk("R7 chained ptr", script_ptr, P + 24);
      chk("R5 second dst", dst_addr, 32'h313);
      chk("R4 masked move copy", {24'h0, mem[10'h312]}, {24'h0, mem[10'h152]});

      // R4 / R8: masked interrupt code 0x9F
      put_be(P + 4, 32'h0);
      put_be(P, 32'h9F000001);
      run(P + 4 - 4);
      chk("R8 masked int ptr", script_ptr, P);
      chk("R8 masked int flag", {31'h0, script_int}, 32'h1);

      // R9 / R4: illegal codes 0xA0 and 0xE0
      put_be(P, 32'hA0000000);
      run(P);
      chk("R9 illegal A0", {28'h0, halted, irq, illegal_int, script_int}, 32'hE);
      chk("R9 ptr kept", script_ptr, P);
      put_be(P + 12, 32'hE0000000);
      run(P + 12);
      chk("R9 illegal E0", {30'h0, illegal_int, script_int}, 32'h2);
      chk("R9 ptr kept E0", script_ptr, P + 12);

      // R2: restart clears illegal status and loads new pointer
      put_be(32'h80, 32'h98000000); put_be(32'h84, 32'h0);
      run(32'h80);
      chk("R2 illegal cleared", {31'h0, illegal_int}, 32'h0);
      chk("R2 ptr loaded", script_ptr, 32'h80);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule